// File: doc/BRIEF.md
# Floating-Point Special-Operand Resolver

This block sits ahead of a single-precision add/subtract/multiply/divide datapath. Each accepted operation brings two 32-bit operands and a 2-bit operation code. The block sorts each operand into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. When the operand classes alone fix the IEEE result, the block produces that result itself. It also asserts `special_o`, which tells the datapath to throw away its own answer for that operation.

The block detects the invalid-operation and divide-by-zero conditions. It keeps five sticky exception flags. The downstream datapath reports overflow, underflow and inexact on dedicated inputs, and those indications are merged into the same sticky flags. A single clear input resets the sticky flags. Significand arithmetic and rounding are outside this block.

Top module: `fp_special_resolver`

## Requirements
- R1: Any NaN operand makes the result special, and the result is the canonical quiet NaN 0x7FC00000. Significand bit 22 set marks a quiet NaN and raises no flag. Bit 22 clear marks a signaling NaN and raises invalid.
- R2: The outputs are registered. `valid_o` is high exactly one cycle after `valid_i`. On a cycle with no valid input, `special_o`, `result_o`, `inv_o` and `dz_o` are 0 in the following cycle.
- R3: Operation codes are 00 add, 01 subtract, 10 multiply, 11 divide. Subtract inverts the sign of B before anything else is decided. Two infinities with the same effective sign give that infinity with no flag. Two infinities with opposite effective signs give the quiet NaN and raise invalid.
- R4: For add/subtract, a finite value combined with an infinity gives the infinity with its effective sign and no flag. Two zeros give a zero that is negative only when both effective signs are negative.
- R5: For multiply, zero times infinity gives the quiet NaN and raises invalid. Infinity times a nonzero value or an infinity gives an infinity with sign A xor B. Zero times a finite value gives a zero with sign A xor B. None of these except the first raises a flag.
- R6: For divide, 0/0 and inf/inf give the quiet NaN and raise invalid. A nonzero finite value divided by zero gives an infinity with sign A xor B and raises divide-by-zero. Inf/finite gives an infinity, and finite/inf and 0/nonzero give a zero, each with sign A xor B and no flag.
- R7: Any other class combination is not special. This includes two nonzero finite operands (subnormals count as nonzero finite) and add with one zero and one nonzero finite operand. In that case `special_o`, `result_o`, `inv_o` and `dz_o` are 0.
- R8: `flags_o` holds the sticky flags as bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. Each bit is set by its event and updates together with the result of the operation that raised it. Each bit stays set until `flag_clr_i` is asserted. Reset clears all five.
- R9: When `flag_clr_i` and a flag event occur in the same cycle, the evented bits end up set and all other bits end up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| flag_clr_i | input | 1 | Clear sticky flags |
| dp_ovf_i | input | 1 | Overflow indication from datapath |
| dp_unf_i | input | 1 | Underflow indication from datapath |
| dp_inx_i | input | 1 | Inexact indication from datapath |
| valid_o | output | 1 | Registered valid |
| special_o | output | 1 | Result is resolved here; datapath result discarded |
| result_o | output | 32 | Resolved result, 0 when not special |
| inv_o | output | 1 | This operation raised invalid |
| dz_o | output | 1 | This operation raised divide-by-zero |
| flags_o | output | 5 | Sticky exception flags |

## Verification
The bench focuses on the sign rules, since they are where a resolver most often goes wrong. If subtract failed to flip B, inf−inf would come out as an infinity instead of an invalid NaN. If the zero-sum sign were handled badly, −0 + +0 would give −0. It drives signaling and quiet NaNs of both signs to catch a design that confuses the quiet bit: that design would raise invalid on a quiet NaN or pass a non-canonical payload through. Subnormal operands are mixed with zeros to catch a design that treats a subnormal as zero, which would report a false divide-by-zero. Clear and event are applied in the same cycle, where a design with the wrong priority would drop the exception.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int NFLAG = 5;

  localparam int F_INV = 0;
  localparam int F_DZ  = 1;
  localparam int F_OVF = 2;
  localparam int F_UNF = 3;
  localparam int F_INX = 4;

  typedef enum logic [2:0] {
    C_ZERO, C_SUB, C_NORM, C_INF, C_QNAN, C_SNAN
  } fcls_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00, OP_SUB = 2'b01, OP_MUL = 2'b10, OP_DIV = 2'b11
  } fop_e;

  typedef struct packed {
    logic  sgn;
    fcls_e cls;
  } fopd_t;

  localparam logic [FP_W-1:0] QNAN_C = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic [FP_W-1:0] mk_inf(logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction

  function automatic logic [FP_W-1:0] mk_zero(logic s);
    return {s, {(FP_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] val_i,
  input  logic           flip_i,
  output fopd_t          opd_o
);
  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;

  assign exp_f = val_i[MW +: EW];
  assign man_f = val_i[MW-1:0];

  always_comb begin
    opd_o.sgn = val_i[EW+MW] ^ flip_i;
    if (exp_f == '0)
      opd_o.cls = (man_f == '0) ? C_ZERO : C_SUB;
    else if (&exp_f)
      opd_o.cls = (man_f == '0) ? C_INF : (man_f[MW-1] ? C_QNAN : C_SNAN);
    else
      opd_o.cls = C_NORM;
  end
endmodule

// File: rtl/fpsr_resolve.sv
module fpsr_resolve
  import fpsr_pkg::*;
(
  input  fop_e            op_i,
  input  fopd_t           opd_a_i,
  input  fopd_t           opd_b_i,
  output logic            hit_o,
  output logic [FP_W-1:0] res_o,
  output logic            inv_o,
  output logic            dz_o
);
  logic a_zero, b_zero, a_inf, b_inf, a_snan, b_snan, a_nan, b_nan;
  logic sa, sb, ps;

  assign a_zero = opd_a_i.cls == C_ZERO;
  assign b_zero = opd_b_i.cls == C_ZERO;
  assign a_inf  = opd_a_i.cls == C_INF;
  assign b_inf  = opd_b_i.cls == C_INF;
  assign a_snan = opd_a_i.cls == C_SNAN;
  assign b_snan = opd_b_i.cls == C_SNAN;
  assign a_nan  = a_snan || opd_a_i.cls == C_QNAN;
  assign b_nan  = b_snan || opd_b_i.cls == C_QNAN;
  assign sa     = opd_a_i.sgn;
  assign sb     = opd_b_i.sgn;
  assign ps     = sa ^ sb;

  always_comb begin
    hit_o = 1'b0;
    res_o = '0;
    inv_o = 1'b0;
    dz_o  = 1'b0;
    if (a_nan || b_nan) begin
      hit_o = 1'b1;
      res_o = QNAN_C;
      inv_o = a_snan || b_snan;
    end else begin
      unique case (op_i)
        OP_ADD, OP_SUB: begin
          if (a_inf && b_inf) begin
            hit_o = 1'b1;
            if (sa == sb) res_o = mk_inf(sa);
            else begin
              res_o = QNAN_C;
              inv_o = 1'b1;
            end
          end else if (a_inf) begin
            hit_o = 1'b1;
            res_o = mk_inf(sa);
          end else if (b_inf) begin
            hit_o = 1'b1;
            res_o = mk_inf(sb);
          end else if (a_zero && b_zero) begin
            hit_o = 1'b1;
            res_o = mk_zero(sa & sb); // round-to-nearest zero sum
          end
        end
        OP_MUL: begin
          if ((a_inf && b_zero) || (a_zero && b_inf)) begin
            hit_o = 1'b1;
            res_o = QNAN_C;
            inv_o = 1'b1;
          end else if (a_inf || b_inf) begin
            hit_o = 1'b1;
            res_o = mk_inf(ps);
          end else if (a_zero || b_zero) begin
            hit_o = 1'b1;
            res_o = mk_zero(ps);
          end
        end
        default: begin
          if ((a_zero && b_zero) || (a_inf && b_inf)) begin
            hit_o = 1'b1;
            res_o = QNAN_C;
            inv_o = 1'b1;
          end else if (a_inf) begin
            hit_o = 1'b1;
            res_o = mk_inf(ps);
          end else if (b_inf) begin
            hit_o = 1'b1;
            res_o = mk_zero(ps);
          end else if (b_zero) begin
            hit_o = 1'b1;
            res_o = mk_inf(ps);
            dz_o  = 1'b1;
          end else if (a_zero) begin
            hit_o = 1'b1;
            res_o = mk_zero(ps);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fpsr_sticky.sv
module fpsr_sticky #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fp_special_resolver.sv
module fp_special_resolver
  import fpsr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [1:0]            op_i,
  input  logic [31:0]           a_i,
  input  logic [31:0]           b_i,
  input  logic                  flag_clr_i,
  input  logic                  dp_ovf_i,
  input  logic                  dp_unf_i,
  input  logic                  dp_inx_i,
  output logic                  valid_o,
  output logic                  special_o,
  output logic [31:0]           result_o,
  output logic                  inv_o,
  output logic                  dz_o,
  output logic [4:0]            flags_o
);
  localparam int NOPD = 2;

  fop_e            op_e;
  logic [FP_W-1:0] opd_raw [NOPD];
  fopd_t           opd     [NOPD];
  logic            hit_c, inv_c, dz_c;
  logic [FP_W-1:0] res_c;
  logic [NFLAG-1:0] flag_set;

  assign op_e       = fop_e'(op_i);
  assign opd_raw[0] = a_i;
  assign opd_raw[1] = b_i;

  for (genvar gi = 0; gi < NOPD; gi++) begin : g_cls
    fpsr_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls (
      .val_i  (opd_raw[gi]),
      .flip_i ((gi == 1) && (op_e == OP_SUB)),
      .opd_o  (opd[gi])
    );
  end

  fpsr_resolve u_res (
    .op_i    (op_e),
    .opd_a_i (opd[0]),
    .opd_b_i (opd[1]),
    .hit_o   (hit_c),
    .res_o   (res_c),
    .inv_o   (inv_c),
    .dz_o    (dz_c)
  );

  always_comb begin
    flag_set        = '0;
    flag_set[F_INV] = valid_i && inv_c;
    flag_set[F_DZ]  = valid_i && dz_c;
    flag_set[F_OVF] = dp_ovf_i;
    flag_set[F_UNF] = dp_unf_i;
    flag_set[F_INX] = dp_inx_i;
  end

  fpsr_sticky #(.N(NFLAG)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (flag_clr_i),
    .set_i   (flag_set),
    .flags_o (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      special_o <= 1'b0;
      result_o  <= '0;
      inv_o     <= 1'b0;
      dz_o      <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      special_o <= valid_i && hit_c;
      result_o  <= valid_i ? res_c : '0;
      inv_o     <= valid_i && inv_c;
      dz_o      <= valid_i && dz_c;
    end
  end
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        flag_clr_i,
  input logic        valid_o,
  input logic        special_o,
  input logic [31:0] result_o,
  input logic        inv_o,
  input logic        dz_o,
  input logic [4:0]  flags_o
);
  assert_nan_canon_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (special_o && result_o[30:23] == 8'hFF && result_o[22:0] != 23'd0) |-> result_o == 32'h7FC00000);

  assert_valid_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!special_o && !inv_o && !dz_o && result_o == 32'd0));

  assert_inv_nan_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> (special_o && result_o == 32'h7FC00000 && !dz_o));

  assert_dz_inf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |-> (special_o && result_o[30:0] == 31'h7F800000));

  assert_nonspecial_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !special_o |-> (result_o == 32'd0 && !inv_o && !dz_o));

  assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> flags_o[0]);

  assert_dz_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |-> flags_o[1]);
endmodule

bind fp_special_resolver fpsr_checker u_chk (.*);

// File: tb/fp_special_resolver_bench.sv
module fp_special_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] a_i = '0, b_i = '0;
  logic        clr_i = 1'b0, ovf_i = 1'b0, unf_i = 1'b0, inx_i = 1'b0;
  logic        valid_o, special_o, inv_o, dz_o;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int n_chk = 0, n_fail = 0;
  logic        e_valid = 1'b0, e_special = 1'b0, e_inv = 1'b0, e_dz = 1'b0;
  logic [31:0] e_res = '0;
  logic [4:0]  e_flags = '0;

  always #2.5 clk = ~clk;

  fp_special_resolver u_fp_special_resolver (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_clr_i(clr_i), .dp_ovf_i(ovf_i), .dp_unf_i(unf_i), .dp_inx_i(inx_i),
    .valid_o(valid_o), .special_o(special_o), .result_o(result_o), .inv_o(inv_o),
    .dz_o(dz_o), .flags_o(flags_o)
  );

  localparam logic [31:0] QN = 32'h7FC00000;

  function automatic bit f_nan(logic [31:0] v);  return v[30:23] == 8'hFF && v[22:0] != 0; endfunction
  function automatic bit f_snan(logic [31:0] v); return f_nan(v) && !v[22]; endfunction
  function automatic bit f_inf(logic [31:0] v);  return v[30:0] == 31'h7F800000; endfunction
  function automatic bit f_zero(logic [31:0] v); return v[30:0] == 31'd0; endfunction

  task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic sp, output logic [31:0] r, output logic iv, output logic dz);
    logic [31:0] bb;
    logic s;
    bb = (op == 2'b01) ? {~b[31], b[30:0]} : b;
    s  = a[31] ^ bb[31];
    sp = 1; r = 0; iv = 0; dz = 0;
    if (f_nan(a) || f_nan(bb)) begin r = QN; iv = f_snan(a) || f_snan(bb); end
    else if (op[1] == 1'b0) begin
      if (f_inf(a) && f_inf(bb) && a[31] != bb[31]) begin r = QN; iv = 1; end
      else if (f_inf(a)) r = a;
      else if (f_inf(bb)) r = bb;
      else if (f_zero(a) && f_zero(bb)) r = {a[31] & bb[31], 31'd0};
      else sp = 0;
    end else if (op == 2'b10) begin
      if ((f_inf(a) && f_zero(bb)) || (f_zero(a) && f_inf(bb))) begin r = QN; iv = 1; end
      else if (f_inf(a) || f_inf(bb)) r = {s, 31'h7F800000};
      else if (f_zero(a) || f_zero(bb)) r = {s, 31'd0};
      else sp = 0;
    end else begin
      if ((f_zero(a) && f_zero(bb)) || (f_inf(a) && f_inf(bb))) begin r = QN; iv = 1; end
      else if (f_inf(a)) r = {s, 31'h7F800000};
      else if (f_inf(bb)) r = {s, 31'd0};
      else if (f_zero(bb)) begin r = {s, 31'h7F800000}; dz = 1; end
      else if (f_zero(a)) r = {s, 31'd0};
      else sp = 0;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare at the following negedge
  task automatic step(input string tag, input logic v, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic clr, input logic [2:0] dp);
    logic sp, iv, dz;
    logic [31:0] r;
    valid_i = v; op_i = op; a_i = a; b_i = b; clr_i = clr;
    {inx_i, unf_i, ovf_i} = dp;
    model(op, a, b, sp, r, iv, dz);
    e_valid = v;
    e_special = v & sp;
    e_res = v ? r : 32'd0;
    e_inv = v & iv;
    e_dz = v & dz;
    e_flags = (clr ? 5'd0 : e_flags) | {dp, v & dz, v & iv};
    @(posedge clk);
    @(negedge clk);
    chk(tag, "valid", {31'd0, valid_o}, {31'd0, e_valid});
    chk(tag, "special", {31'd0, special_o}, {31'd0, e_special});
    chk(tag, "result", result_o, e_res);
    chk(tag, "inv", {31'd0, inv_o}, {31'd0, e_inv});
    chk(tag, "dz", {31'd0, dz_o}, {31'd0, e_dz});
    chk(tag, "flags", {27'd0, flags_o}, {27'd0, e_flags});
  endtask

  function automatic logic [31:0] pick(int k);
    case (k)
      0: return 32'h00000000;  1: return 32'h80000000;
      2: return 32'h3F800000;  3: return 32'hBF800000;
      4: return 32'h7F800000;  5: return 32'hFF800000;
      6: return 32'h7FC00000;  7: return 32'h7F800001;
      8: return 32'hFFC12345;  9: return 32'h00000001;
      10: return 32'h807FFFFF; default: return 32'h40490FDB;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", "reset valid", {31'd0, valid_o}, 32'd0);
    chk("R8", "reset flags", {27'd0, flags_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 NaN handling
    step("R1", 1, 2'b00, 32'h7FC00000, 32'h3F800000, 0, 3'b000);
    step("R1", 1, 2'b10, 32'h3F800000, 32'hFFA00001, 0, 3'b000);
    step("R1", 1, 2'b11, 32'h7FD00000, 32'h00000000, 1, 3'b000);
    // R2 idle cycle
    step("R2", 0, 2'b11, 32'h00000000, 32'h00000000, 0, 3'b000);
    // R3 infinities
    step("R3", 1, 2'b00, 32'h7F800000, 32'hFF800000, 1, 3'b000);
    step("R3", 1, 2'b01, 32'h7F800000, 32'hFF800000, 1, 3'b000);
    step("R3", 1, 2'b01, 32'h7F800000, 32'h7F800000, 1, 3'b000);
    // R4 finite+inf, signed zero sums
    step("R4", 1, 2'b01, 32'h3F800000, 32'h7F800000, 1, 3'b000);
    step("R4", 1, 2'b00, 32'h80000000, 32'h00000000, 0, 3'b000);
    step("R4", 1, 2'b01, 32'h80000000, 32'h00000000, 0, 3'b000);
    // R5 multiply
    step("R5", 1, 2'b10, 32'h80000000, 32'h7F800000, 1, 3'b000);
    step("R5", 1, 2'b10, 32'hFF800000, 32'h00000001, 1, 3'b000);
    step("R5", 1, 2'b10, 32'h80000000, 32'h3F800000, 0, 3'b000);
    // R6 divide
    step("R6", 1, 2'b11, 32'hBF800000, 32'h00000000, 1, 3'b000);
    step("R6", 1, 2'b11, 32'h00000001, 32'h80000000, 1, 3'b000);
    step("R6", 1, 2'b11, 32'h3F800000, 32'hFF800000, 1, 3'b000);
    step("R6", 1, 2'b11, 32'hFF800000, 32'h7F800000, 1, 3'b000);
    // R7 non-special
    step("R7", 1, 2'b00, 32'h00000000, 32'h00000001, 1, 3'b000);
    step("R7", 1, 2'b11, 32'h807FFFFF, 32'h40490FDB, 0, 3'b000);
    // R8 datapath merge and hold
    step("R8", 1, 2'b10, 32'h3F800000, 32'h3F800000, 1, 3'b001);
    step("R8", 0, 2'b00, 32'h0, 32'h0, 0, 3'b110);
    step("R8", 0, 2'b00, 32'h0, 32'h0, 0, 3'b000);
    step("R8", 0, 2'b00, 32'h0, 32'h0, 1, 3'b000);
    // R9 clear with simultaneous event
    step("R9", 1, 2'b00, 32'h7F800001, 32'h0, 0, 3'b000);
    step("R9", 1, 2'b11, 32'h00000000, 32'h00000000, 1, 3'b100);
    step("R9", 1, 2'b11, 32'h3F800000, 32'h00000000, 1, 3'b000);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      step(op[1] ? (op[0] ? "R6" : "R5") : "R3", 1'($urandom_range(0, 7) != 0), op,
           pick(int'($urandom_range(0, 11))), pick(int'($urandom_range(0, 11))),
           1'($urandom_range(0, 5) == 0), 3'($urandom_range(0, 7) & {3{$urandom_range(0, 3) == 0}}));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule